// File: doc/BRIEF.md
# Paged EEPROM Write Buffer Controller

This block is the storage half of a small serial EEPROM model. It holds a byte array whose depth is set by a parameter (512 or 1024 bytes) and starts with every byte at 0xFF, the erased value. A bus-side protocol engine drives it with simple strobes. One strobe loads a start address. Another loads one data byte. A third samples the write-protect level. The last one is a commit strobe, issued when the bus transaction ends.

Data bytes do not go straight into the array. They collect in a 16-byte page buffer, and a per-position valid mask records which buffer slots were loaded. The page part of the start address is fixed by the address load. Each byte load advances only the low four pointer bits, so a long burst wraps round inside the page and later bytes overwrite earlier ones. On commit, every loaded slot is copied into the array during one internal write cycle of fixed length, and `busy` stays high for the whole cycle. The unloaded slots of the page keep their old contents. A request that was write-protected is dropped without touching the array. A commit with nothing loaded starts no cycle at all.

Reads go through a synchronous read port with one clock of latency. The current address pointer is also an output, so the protocol engine can run current-address reads from it.

Top module: `eepb_core`

## Requirements
- R1: After reset `busy` is 0, `ptr` is 0 and every array location reads 0xFF. `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is applied.
- R2: When idle, `addr_ld` sets `ptr` to `addr_in` on the next clock.
- R3: When idle, `byte_ld` stores `byte_in` in the buffer slot chosen by `ptr[3:0]` and increments only `ptr[3:0]` (15 wraps to 0; the upper bits are unchanged). A later byte that lands in the same slot replaces the earlier one.
- R4: A commit with at least one slot loaded and no protection pending raises `busy` on the next clock. `busy` stays high for exactly WRITE_CYCLES clocks, and after that every loaded slot is in the array at {page, slot}.
- R5: A commit writes only the slots loaded since the last commit. The other locations of the page keep their previous values.
- R6: If `wp_strobe` sampled `wp_level`=1 after the most recent address load, the next commit is rejected: `busy` stays 0 and no array location changes. `addr_ld` and every commit clear the protect flag. A `wp_strobe` with `wp_level`=0 also clears it.
- R7: A commit with no slots loaded leaves `busy` at 0.
- R8: The valid mask is empty after every completed write cycle and after every rejected commit. A later commit therefore writes only the bytes loaded after that point.
- R9: While `busy` is 1, `addr_ld`, `byte_ld`, `wp_strobe` and `commit` have no effect.
- R10: After a commit, `ptr` holds the slot after the last loaded byte, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load start address strobe |
| addr_in | input | ADDR_W | Start address |
| byte_ld | input | 1 | Load one data byte strobe |
| byte_in | input | 8 | Data byte |
| wp_strobe | input | 1 | Sample write-protect level strobe |
| wp_level | input | 1 | Write-protect level (1 = protect) |
| commit | input | 1 | End-of-transaction strobe; starts the write cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Internal write cycle in progress |
| ptr | output | ADDR_W | Current address pointer |

## Verification
The bench goes after several corner cases, each tied to a specific fault:
- A burst of more than sixteen bytes that starts near the end of a page. A design that carried into the page bits would write into the next page and leave the pointer outside the page.
- A partial page write over earlier data. A design that wrote the whole buffer would overwrite the neighbours with stale or erased bytes.
- A protected request followed by a single unprotected byte. A design that kept the old mask would commit the rejected bytes as well.
- An empty commit, and strobes issued while busy. These expose a spurious busy window, a pointer that moved, or a byte that was taken during the write cycle.

Random transactions, some with protection and some with no data, are compared against a model of the array kept in the bench.

// File: rtl/eepb_pkg.sv
package eepb_pkg;
  typedef logic [7:0] byte_t;

  // advance an in-page offset by one, wrapping at the page size
  function automatic logic [7:0] slot_next(input logic [7:0] slot, input int page_bytes);
    return (int'(slot) == page_bytes - 1) ? 8'd0 : slot + 8'd1;
  endfunction
endpackage

// File: rtl/eepb_array.sv
module eepb_array #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  eepb_pkg::byte_t      wdata,
  input  logic [ADDR_W-1:0]    raddr,
  output eepb_pkg::byte_t      rdata
);
  eepb_pkg::byte_t mem [DEPTH];

  // erased contents at configuration time
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eepb_page_buf.sv
module eepb_page_buf #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busy,
  input  logic                  done,
  input  logic                  addr_ld,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic                  byte_ld,
  input  eepb_pkg::byte_t       byte_in,
  input  logic                  wp_strobe,
  input  logic                  wp_level,
  input  logic                  commit,
  input  logic [OFF_W-1:0]      sel_idx,
  output eepb_pkg::byte_t       sel_data,
  output logic                  sel_vld,
  output logic [PG_W-1:0]       page_q,
  output logic [OFF_W-1:0]      off_q,
  output logic [PAGE_BYTES-1:0] vld_mask,
  output logic                  prot_q,
  output logic                  start
);
  eepb_pkg::byte_t slot_q [PAGE_BYTES];

  logic idle, addr_ok, byte_ok, commit_ok, clear;
  logic [7:0] off_nxt;

  assign idle      = !busy;
  assign addr_ok   = addr_ld & idle;
  assign byte_ok   = byte_ld & idle & !addr_ld;
  assign commit_ok = commit & idle;
  assign start     = commit_ok & !prot_q & (|vld_mask);
  assign clear     = done | (commit_ok & prot_q);
  assign off_nxt   = eepb_pkg::slot_next(8'(off_q), PAGE_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
      prot_q <= 1'b0;
    end else begin
      if (addr_ok) begin
        page_q <= addr_in[ADDR_W-1:OFF_W];
        off_q  <= addr_in[OFF_W-1:0];
      end else if (byte_ok) begin
        off_q  <= off_nxt[OFF_W-1:0];
      end
      if (commit_ok || addr_ok) prot_q <= 1'b0;
      else if (idle && wp_strobe) prot_q <= wp_level;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_mask[i] <= 1'b0;
        slot_q[i]   <= 8'hFF;
      end else if (clear) begin
        vld_mask[i] <= 1'b0;
      end else if (byte_ok && off_q == OFF_W'(i)) begin
        vld_mask[i] <= 1'b1;
        slot_q[i]   <= byte_in;
      end
    end
  end

  assign sel_data = slot_q[sel_idx];
  assign sel_vld  = vld_mask[sel_idx];
endmodule

// File: rtl/eepb_wr_seq.sv
module eepb_wr_seq #(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int CW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             wr_act,
  output logic [OFF_W-1:0] wr_idx
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (done) begin
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // slots are copied one per clock at the start of the window
  assign done   = busy && (cnt_q == CW'(WRITE_CYCLES - 1));
  assign wr_act = busy && (cnt_q < CW'(PAGE_BYTES));
  assign wr_idx = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/eepb_core.sv
module eepb_core #(
  parameter int  MEM_DEPTH    = 512,
  parameter int  PAGE_BYTES   = 16,
  parameter int  WRITE_CYCLES = 40,
  localparam int ADDR_W       = $clog2(MEM_DEPTH),
  localparam int OFF_W        = $clog2(PAGE_BYTES),
  localparam int PG_W         = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_ld,
  input  logic [7:0]        byte_in,
  input  logic              wp_strobe,
  input  logic              wp_level,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);
  logic                  done, wr_act, start, sel_vld, prot_q;
  logic [OFF_W-1:0]      wr_idx, off_q;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] vld_mask;
  eepb_pkg::byte_t       sel_data;

  eepb_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .addr_ld(addr_ld), .addr_in(addr_in), .byte_ld(byte_ld), .byte_in(byte_in),
    .wp_strobe(wp_strobe), .wp_level(wp_level), .commit(commit),
    .sel_idx(wr_idx), .sel_data(sel_data), .sel_vld(sel_vld),
    .page_q(page_q), .off_q(off_q), .vld_mask(vld_mask), .prot_q(prot_q),
    .start(start)
  );

  eepb_wr_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .wr_act(wr_act), .wr_idx(wr_idx)
  );

  eepb_array #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(wr_act & sel_vld), .waddr({page_q, wr_idx}), .wdata(sel_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign ptr = {page_q, off_q};
endmodule

// File: rtl/eepb_core_chk.sv
module eepb_core_chk #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  commit,
  input logic                  busy,
  input logic [ADDR_W-1:0]     ptr,
  input logic [PAGE_BYTES-1:0] vld_mask,
  input logic                  prot
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_q <= 0;
    else              run_q <= run_q + 1;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == WRITE_CYCLES); // R4
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit)); // R4
  AST_PROT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (commit && !busy && prot) |=> !busy); // R6
  AST_EMPTY_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (commit && !busy && vld_mask == '0) |=> !busy); // R7
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> vld_mask == '0); // R8
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr)); // R9
endmodule

bind eepb_core eepb_core_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .busy(busy), .ptr(ptr),
  .vld_mask(vld_mask), .prot(prot_q)
);

// File: tb/eepb_core_test.sv
`timescale 1ns/1ps
module eepb_core_test;
  localparam int DEPTH = 512;
  localparam int AW    = 9;
  localparam int WCYC  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_ld = 0, byte_ld = 0, wp_strobe = 0, wp_level = 0, commit = 0;
  logic [AW-1:0] addr_in = '0, rd_addr = '0;
  logic [7:0] byte_in = '0;
  logic [7:0] rd_data;
  logic busy;
  logic [AW-1:0] ptr;

  int checks = 0, fails = 0;

  // bench model
  logic [7:0]    mm [DEPTH];
  logic [7:0]    m_buf [16];
  bit            m_vld [16];
  logic [AW-1:0] m_ptr;
  bit            m_prot;

  always #5 clk = ~clk;

  eepb_core #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) uut (
    .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_ld(byte_ld), .byte_in(byte_in), .wp_strobe(wp_strobe), .wp_level(wp_level),
    .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .ptr(ptr)
  );

  function automatic logic [AW-1:0] ptr_after(input logic [AW-1:0] p);
    return {p[AW-1:4], 4'(p[3:0] + 4'd1)};
  endfunction

  function automatic bit any_loaded();
    for (int i = 0; i < 16; i++) if (m_vld[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_ld = 1; addr_in = a;
    @(negedge clk); addr_ld = 0;
    m_ptr = a; m_prot = 0;
  endtask

  task automatic t_byte(input logic [7:0] b);
    @(negedge clk); byte_ld = 1; byte_in = b;
    @(negedge clk); byte_ld = 0;
    m_buf[m_ptr[3:0]] = b; m_vld[m_ptr[3:0]] = 1; m_ptr = ptr_after(m_ptr);
  endtask

  task automatic t_wp(input bit lvl);
    @(negedge clk); wp_strobe = 1; wp_level = lvl;
    @(negedge clk); wp_strobe = 0; wp_level = 0;
    m_prot = lvl;
  endtask

  task automatic t_commit();
    int blen;
    bit go;
    string tag;
    go  = !m_prot && any_loaded();
    tag = m_prot ? "R6" : (go ? "R4" : "R7");
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    blen = 0;
    while (busy && blen < 1000) begin blen++; @(negedge clk); end
    chk(tag, "busy length", blen, go ? WCYC : 0);
    if (go)
      for (int i = 0; i < 16; i++)
        if (m_vld[i]) mm[{m_ptr[AW-1:4], 4'(i)}] = m_buf[i];
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    m_prot = 0;
    chk("R10", "ptr after commit", int'(ptr), int'(m_ptr));
  endtask

  task automatic t_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic chk_page(input string req, input logic [AW-1:0] a);
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      t_rd({a[AW-1:4], 4'(i)}, d);
      chk(req, "array byte", int'(d), int'(mm[{a[AW-1:4], 4'(i)}]));
    end
  endtask

  // watchdog
  initial begin
    #1500us;
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [AW-1:0] sa;
    int blen, n;
    for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    m_ptr = '0; m_prot = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state and erased array
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "ptr after reset", int'(ptr), 0);
    t_rd(9'h000, d); chk("R1", "erased byte 0", int'(d), 8'hFF);
    t_rd(9'h1FF, d); chk("R1", "erased top byte", int'(d), 8'hFF);

    // R2 address load, R4 single byte write
    t_addr(9'h023);
    chk("R2", "ptr after load", int'(ptr), 9'h023);
    t_byte(8'hA5);
    chk("R3", "ptr advance", int'(ptr), 9'h024);
    t_commit();
    chk_page("R4", 9'h020);

    // R5 partial page keeps neighbours
    t_addr(9'h028); t_byte(8'h3C); t_byte(8'h4D);
    t_commit();
    t_rd(9'h023, d); chk("R5", "older byte kept", int'(d), 8'hA5);
    chk_page("R5", 9'h020);

    // R3 wrap within page with overwrite, 18 bytes from offset 0xE
    t_addr(9'h01E);
    for (int i = 0; i < 18; i++) t_byte(8'(8'h60 + i));
    chk("R3", "ptr wrapped", int'(ptr), 9'h010);
    t_commit();
    t_rd(9'h01E, d); chk("R3", "slot E overwritten", int'(d), 8'h70);
    t_rd(9'h020, d); chk("R3", "next page untouched", int'(d), 8'hFF);
    chk_page("R3", 9'h010);

    // R6 protect rejects; R8 mask cleared afterwards
    t_addr(9'h0A0); t_wp(1'b1);
    t_byte(8'hEE); t_byte(8'hEF);
    t_commit();
    chk_page("R6", 9'h0A0);
    t_addr(9'h0A5); t_byte(8'h42);
    t_commit();
    t_rd(9'h0A0, d); chk("R8", "rejected byte not committed", int'(d), 8'hFF);
    t_rd(9'h0A5, d); chk("R8", "new byte committed", int'(d), 8'h42);

    // R6 low level clears protect
    t_addr(9'h0B0); t_wp(1'b1); t_wp(1'b0); t_byte(8'h77);
    t_commit();
    t_rd(9'h0B0, d); chk("R6", "unprotected after low sample", int'(d), 8'h77);

    // R7 empty commit
    t_addr(9'h0C4);
    t_commit();

    // R9 strobes ignored while busy
    t_addr(9'h040); t_byte(8'h11);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    addr_ld = 1; addr_in = 9'h080;
    @(negedge clk); addr_ld = 0; byte_ld = 1; byte_in = 8'h99;
    @(negedge clk); byte_ld = 0; wp_strobe = 1; wp_level = 1;
    @(negedge clk); wp_strobe = 0; wp_level = 0; commit = 1;
    @(negedge clk); commit = 0;
    blen = 0;
    while (busy && blen < 1000) begin blen++; @(negedge clk); end
    mm[9'h040] = 8'h11; m_ptr = 9'h041;
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    chk("R9", "ptr unchanged by busy strobes", int'(ptr), 9'h041);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    chk("R9", "no byte taken during busy", int'(busy), 0);
    t_rd(9'h041, d); chk("R9", "slot after busy untouched", int'(d), 8'hFF);
    t_rd(9'h080, d); chk("R9", "ignored address untouched", int'(d), 8'hFF);
    t_rd(9'h040, d); chk("R4", "byte before busy", int'(d), 8'h11);

    // top page boundary
    t_addr(9'h1FF); t_byte(8'hB1); t_byte(8'hB2);
    chk("R3", "ptr wraps at top page", int'(ptr), 9'h1F1);
    t_commit();
    chk_page("R3", 9'h1F0);

    // random transactions
    for (int k = 0; k < 14; k++) begin
      sa = AW'($urandom % DEPTH);
      n  = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 20);
      t_addr(sa);
      if ($urandom % 4 == 0) t_wp(1'b1);
      for (int i = 0; i < n; i++) t_byte(8'($urandom));
      t_commit();
      chk_page("R5", sa);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule